// File: doc/BRIEF.md
# PoE Port Detection Sequencer

This block is the control sequencer for one port of a power-sourcing Ethernet switch or injector. It takes a port from idle through two detection phases and one classification phase, applies power by driving a gate enable, waits for power-good, and then watches for the load going away. The analog front end is outside the block. It supplies a 3-bit detection verdict, a classification-done strobe, a power-good flag and a DC-disconnect flag. Register logic supplies the mode, the detect-enable and class-enable set pulses, a backoff enable, and power-on and power-off command pulses.

Every phase timer counts ticks of a clock prescaler. The verdict, class-done, power-good and disconnect inputs first pass through a synchroniser. The verdict, class-done and power-good inputs are then acted on only at a tick.

Three modes decide how the two enable bits behave:

- **Automatic mode** keeps both bits set and runs all the way to power-up without software.
- **Manual mode** treats each bit as a one-shot: the bit starts its routine and then clears itself.
- **Semi-automatic mode** repeats detection and classification while software holds the bits. It leaves power-up to the power-on command.

Top module: `pse_port_seq`

## Requirements
- R1: After reset, phase is idle (0), gateEn, pwrEnabled and startFault are low, detResult is 000, and both enable bits are clear.
- R2: The mode input encodes manual as 0 or 3, semi-automatic as 1 and automatic as 2. The cycle after the mode changes into automatic, both enable bits are set. The cycle after the mode changes into manual, both are clear. Entering semi-automatic leaves them unchanged. A mode change never alters the phase.
- R3: Phase codes are idle 0, first detection 1, second detection 2, classification 3, startup 4, powered 5 and backoff 6. With detect enable set, an idle port enters phase 1, then phase 2. Each detection phase lasts DET_TICKS ticks.
- R4: At the end of phase 2 the synchronised verdict is latched onto detResult. Nowhere else does detResult change. Only verdict 100 (pass) may lead on to classification: with class enable set the port goes to phase 3, and otherwise it goes to idle.
- R5: A failing verdict with backoff enabled moves the port to phase 6. The port stays there between (BACKOFF_TICKS-1)*PRESCALE+1 and BACKOFF_TICKS*PRESCALE clock cycles, then returns to idle. With backoff disabled, a failing verdict goes straight to idle.
- R6: In manual mode, detect enable clears when the port leaves detection, and class enable clears when it leaves classification. The port then rests in idle.
- R7: Classification ends on the first tick at which class-done is seen, or after CLASS_TICKS ticks. From there an automatic-mode port goes to startup and any other mode returns to idle.
- R8: A power-on command while the port is in phase 0, 1, 2, 3 or 6 moves it to startup in the next cycle, with gateEn high. Any detection or classification in progress is abandoned.
- R9: In startup, power-good seen at a tick moves the port to powered, where pwrEnabled is high. If power-good is not seen within PGOOD_TICKS ticks, the port returns to idle with the gate off, and startFault is high for exactly one cycle.
- R10: In powered, a synchronised disconnect flag with disconnect monitoring enabled returns the port to idle and drops the gate. With monitoring disabled, the flag has no effect.
- R11: A power-off command returns the port to idle with the gate off in the next cycle, from any phase. In semi-automatic mode it also clears both enable bits.
- R12: gateEn is high exactly in startup and powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Operating mode (0/3 manual, 1 semi, 2 automatic) |
| detEnSet | input | 1 | One-cycle pulse setting detect enable |
| classEnSet | input | 1 | One-cycle pulse setting class enable |
| backoffEn | input | 1 | Insert backoff delay after a failed detection |
| pwrOnCmd | input | 1 | One-cycle power-on command |
| pwrOffCmd | input | 1 | One-cycle power-off command |
| dcdEn | input | 1 | Enable DC disconnect monitoring |
| detVerdict | input | 3 | Detection verdict code from the front end |
| classDone | input | 1 | Classification complete |
| pwrGood | input | 1 | Port output voltage is good |
| dcDisconnect | input | 1 | DC load absence flag |
| gateEn | output | 1 | Drive to the port pass transistor |
| phase | output | 3 | Current phase code |
| detResult | output | 3 | Last latched detection verdict |
| pwrEnabled | output | 1 | Port is in the powered phase |
| detEnBit | output | 1 | Detect enable bit |
| classEnBit | output | 1 | Class enable bit |
| startFault | output | 1 | One-cycle startup-timeout pulse |

## Verification
The hardest state to reach is the semi-automatic power-off case. In that mode a passing port loops through detection and classification forever, so the bench has to land its power-off command inside one particular pass. To do this, the bench queues the whole expected phase trail. It waits until the scoreboard has consumed every entry up to the second entry into detection, then issues the command. The detection phase lasts many ticks, so the command always lands there, and the trail must end in idle with both enables cleared. The power-on abort follows the same pattern: the bench waits until detection is seen, issues the command, and then holds power-good low so that the startup timer runs out.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DET1    = 3'd1,
    PH_DET2    = 3'd2,
    PH_CLASS   = 3'd3,
    PH_START   = 3'd4,
    PH_POWER   = 3'd5,
    PH_BACKOFF = 3'd6
  } phase_e;

  localparam logic [2:0] VERDICT_PASS = 3'b100;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic latchVerdict;
    logic clrDetEn;
    logic clrClassEn;
  } seq_strobe_t;

  function automatic logic modeIsManual(input logic [1:0] m);
    return (m == 2'd0) || (m == 2'd3);
  endfunction

  function automatic logic modeIsSemi(input logic [1:0] m);
    return m == 2'd1;
  endfunction

  function automatic logic modeIsAuto(input logic [1:0] m);
    return m == 2'd2;
  endfunction

endpackage

// File: rtl/pse_seq_dp.sv
module pse_seq_dp
  import pse_seq_pkg::*;
#(
  parameter int PRESCALE    = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strobe,
  input  logic [1:0]       modeSel,
  input  logic             detEnSet,
  input  logic             classEnSet,
  input  logic [2:0]       detVerdictIn,
  input  logic             classDoneIn,
  input  logic             pwrGoodIn,
  input  logic             dcDiscIn,
  output logic             tick,
  output logic [CNT_W-1:0] tickCnt,
  output logic [2:0]       verdictS,
  output logic             classDoneS,
  output logic             pwrGoodS,
  output logic             dcDiscS,
  output logic [2:0]       detResult,
  output logic             detEn,
  output logic             classEn
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SW   = 6;

  // input synchroniser chain
  logic [SW-1:0] rawIn;
  logic [SYNC_STAGES-1:0][SW-1:0] syncQ;
  assign rawIn = {detVerdictIn, classDoneIn, pwrGoodIn, dcDiscIn};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign {verdictS, classDoneS, pwrGoodS, dcDiscS} = syncQ[SYNC_STAGES-1];

  // tick prescaler
  logic [PS_W-1:0] psCnt;
  assign tick = (psCnt == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rstN || tick) psCnt <= '0;
    else               psCnt <= psCnt + 1'b1;
  end

  // phase timer in ticks, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.timerClr) tickCnt <= '0;
    else if (tick && (tickCnt != '1)) tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    detResult <= '0;
    else if (strobe.latchVerdict) detResult <= verdictS;
  end

  // enable bits with mode-entry rules
  logic [1:0] modePrev;
  logic enterAuto, enterManual;
  assign enterAuto   = modeIsAuto(modeSel) && !modeIsAuto(modePrev);
  assign enterManual = modeIsManual(modeSel) && !modeIsManual(modePrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev <= 2'd0;
      detEn    <= 1'b0;
      classEn  <= 1'b0;
    end else begin
      modePrev <= modeSel;
      if (enterAuto)             detEn <= 1'b1;
      else if (enterManual)      detEn <= 1'b0;
      else if (strobe.clrDetEn)  detEn <= 1'b0;
      else if (detEnSet)         detEn <= 1'b1;
      if (enterAuto)              classEn <= 1'b1;
      else if (enterManual)       classEn <= 1'b0;
      else if (strobe.clrClassEn) classEn <= 1'b0;
      else if (classEnSet)        classEn <= 1'b1;
    end
  end

endmodule

// File: rtl/pse_seq_ctrl.sv
module pse_seq_ctrl
  import pse_seq_pkg::*;
#(
  parameter int DET_TICKS     = 80,
  parameter int CLASS_TICKS   = 22,
  parameter int PGOOD_TICKS   = 60,
  parameter int BACKOFF_TICKS = 150,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             backoffEn,
  input  logic             dcdEn,
  input  logic             pwrOnCmd,
  input  logic             pwrOffCmd,
  input  logic             tick,
  input  logic [CNT_W-1:0] tickCnt,
  input  logic [2:0]       verdictS,
  input  logic             classDoneS,
  input  logic             pwrGoodS,
  input  logic             dcDiscS,
  input  logic             detEn,
  input  logic             classEn,
  output seq_strobe_t      strobe,
  output phase_e           phase,
  output logic             gateEn,
  output logic             pwrEnabled,
  output logic             startFault
);

  phase_e state, nextState;

  logic detDone, classOver, pgoodOver, backoffOver;
  assign detDone     = tick && (tickCnt == CNT_W'(DET_TICKS - 1));
  assign classOver   = tick && (tickCnt == CNT_W'(CLASS_TICKS - 1));
  assign pgoodOver   = tick && (tickCnt == CNT_W'(PGOOD_TICKS - 1));
  assign backoffOver = tick && (tickCnt == CNT_W'(BACKOFF_TICKS - 1));

  logic inDet, nextInDet, powerSide;
  assign inDet     = (state == PH_DET1) || (state == PH_DET2);
  assign nextInDet = (nextState == PH_DET1) || (nextState == PH_DET2);
  assign powerSide = (state == PH_START) || (state == PH_POWER);

  always_comb begin
    nextState           = state;
    startFault          = 1'b0;
    strobe              = '0;
    unique case (state)
      PH_IDLE:    if (detEn) nextState = PH_DET1;
      PH_DET1:    if (detDone) nextState = PH_DET2;
      PH_DET2: begin
        if (detDone) begin
          strobe.latchVerdict = 1'b1;
          if (verdictS == VERDICT_PASS) nextState = classEn ? PH_CLASS : PH_IDLE;
          else                          nextState = backoffEn ? PH_BACKOFF : PH_IDLE;
        end
      end
      PH_CLASS:
        if ((tick && classDoneS) || classOver)
          nextState = modeIsAuto(modeSel) ? PH_START : PH_IDLE;
      PH_START: begin
        if (tick && pwrGoodS) nextState = PH_POWER;
        else if (pgoodOver) begin
          nextState  = PH_IDLE;
          startFault = 1'b1;
        end
      end
      PH_POWER:   if (dcdEn && dcDiscS) nextState = PH_IDLE;
      PH_BACKOFF: if (backoffOver) nextState = PH_IDLE;
      default:    nextState = PH_IDLE;
    endcase

    // command overrides: power-off beats power-on
    if (pwrOnCmd && !powerSide) begin
      nextState  = PH_START;
      startFault = 1'b0;
    end
    if (pwrOffCmd) begin
      nextState  = PH_IDLE;
      startFault = 1'b0;
    end

    // manual pushbutton clearing and semi-auto power-off clearing
    if (modeIsManual(modeSel) && inDet && !nextInDet) strobe.clrDetEn = 1'b1;
    if (modeIsManual(modeSel) && (state == PH_CLASS) && (nextState != PH_CLASS))
      strobe.clrClassEn = 1'b1;
    if (modeIsSemi(modeSel) && pwrOffCmd) begin
      strobe.clrDetEn   = 1'b1;
      strobe.clrClassEn = 1'b1;
    end
    strobe.timerClr = (nextState != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  assign phase      = state;
  assign gateEn     = powerSide;
  assign pwrEnabled = (state == PH_POWER);

endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
  import pse_seq_pkg::*;
#(
  parameter int PRESCALE      = 1000,
  parameter int SYNC_STAGES   = 2,
  parameter int DET_TICKS     = 80,
  parameter int CLASS_TICKS   = 22,
  parameter int PGOOD_TICKS   = 60,
  parameter int BACKOFF_TICKS = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       detEnSet,
  input  logic       classEnSet,
  input  logic       backoffEn,
  input  logic       pwrOnCmd,
  input  logic       pwrOffCmd,
  input  logic       dcdEn,
  input  logic [2:0] detVerdict,
  input  logic       classDone,
  input  logic       pwrGood,
  input  logic       dcDisconnect,
  output logic       gateEn,
  output logic [2:0] phase,
  output logic [2:0] detResult,
  output logic       pwrEnabled,
  output logic       detEnBit,
  output logic       classEnBit,
  output logic       startFault
);

  localparam int MAX_A     = (DET_TICKS > CLASS_TICKS) ? DET_TICKS : CLASS_TICKS;
  localparam int MAX_B     = (PGOOD_TICKS > BACKOFF_TICKS) ? PGOOD_TICKS : BACKOFF_TICKS;
  localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  seq_strobe_t      strobe;
  phase_e           phaseQ;
  logic             tick;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       verdictS;
  logic             classDoneS, pwrGoodS, dcDiscS;

  pse_seq_dp #(
    .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeSel(modeSel),
    .detEnSet(detEnSet), .classEnSet(classEnSet),
    .detVerdictIn(detVerdict), .classDoneIn(classDone),
    .pwrGoodIn(pwrGood), .dcDiscIn(dcDisconnect),
    .tick(tick), .tickCnt(tickCnt), .verdictS(verdictS),
    .classDoneS(classDoneS), .pwrGoodS(pwrGoodS), .dcDiscS(dcDiscS),
    .detResult(detResult), .detEn(detEnBit), .classEn(classEnBit)
  );

  pse_seq_ctrl #(
    .DET_TICKS(DET_TICKS), .CLASS_TICKS(CLASS_TICKS),
    .PGOOD_TICKS(PGOOD_TICKS), .BACKOFF_TICKS(BACKOFF_TICKS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .backoffEn(backoffEn),
    .dcdEn(dcdEn), .pwrOnCmd(pwrOnCmd), .pwrOffCmd(pwrOffCmd),
    .tick(tick), .tickCnt(tickCnt), .verdictS(verdictS),
    .classDoneS(classDoneS), .pwrGoodS(pwrGoodS), .dcDiscS(dcDiscS),
    .detEn(detEnBit), .classEn(classEnBit), .strobe(strobe),
    .phase(phaseQ), .gateEn(gateEn), .pwrEnabled(pwrEnabled),
    .startFault(startFault)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/pse_port_seq_chk.sv
module pse_port_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       pwrOnCmd,
  input logic       pwrOffCmd,
  input logic       gateEn,
  input logic [2:0] phase,
  input logic [2:0] detResult,
  input logic       detEnBit,
  input logic       classEnBit,
  input logic       startFault
);

  assert_enter_auto_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd2 && $past(modeSel) != 2'd2) |=> (detEnBit && classEnBit));

  assert_enter_manual_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0 && ($past(modeSel) == 2'd1 || $past(modeSel) == 2'd2))
      |=> (!detEnBit && !classEnBit));

  assert_result_only_after_det2_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(detResult) |-> ($past(phase) == 3'd2));

  assert_pwron_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOnCmd && !pwrOffCmd && phase != 3'd4 && phase != 3'd5)
      |=> (phase == 3'd4 && gateEn));

  assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    startFault |=> (!startFault && phase == 3'd0 && !gateEn));

  assert_pwroff_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffCmd |=> (phase == 3'd0 && !gateEn));

endmodule

bind pse_port_seq pse_port_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .pwrOnCmd(pwrOnCmd),
  .pwrOffCmd(pwrOffCmd), .gateEn(gateEn), .phase(phase),
  .detResult(detResult), .detEnBit(detEnBit), .classEnBit(classEnBit),
  .startFault(startFault)
);

// File: tb/pse_port_seq_tb.sv
module pse_port_seq_tb;

  localparam int P  = 4;
  localparam int DT = 3;
  localparam int CT = 4;
  localparam int PT = 5;
  localparam int BT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic detEnSet = 0, classEnSet = 0, backoffEn = 0, pwrOnCmd = 0, pwrOffCmd = 0;
  logic dcdEn = 0, classDone = 0, pwrGood = 0, dcDisconnect = 0;
  logic [2:0] detVerdict = 3'b000;
  logic gateEn, pwrEnabled, detEnBit, classEnBit, startFault;
  logic [2:0] phase, detResult;

  always #2.5 clk = ~clk;

  pse_port_seq #(
    .PRESCALE(P), .SYNC_STAGES(2), .DET_TICKS(DT), .CLASS_TICKS(CT),
    .PGOOD_TICKS(PT), .BACKOFF_TICKS(BT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .detEnSet(detEnSet),
    .classEnSet(classEnSet), .backoffEn(backoffEn), .pwrOnCmd(pwrOnCmd),
    .pwrOffCmd(pwrOffCmd), .dcdEn(dcdEn), .detVerdict(detVerdict),
    .classDone(classDone), .pwrGood(pwrGood), .dcDisconnect(dcDisconnect),
    .gateEn(gateEn), .phase(phase), .detResult(detResult),
    .pwrEnabled(pwrEnabled), .detEnBit(detEnBit), .classEnBit(classEnBit),
    .startFault(startFault)
  );

  int vectors = 0;
  int miscompares = 0;
  int faultPulses = 0;
  int expQ[$];
  logic [2:0] lastPhase = 3'd0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every phase change must match the next expected entry
  always @(negedge clk) begin
    if (!rstN) lastPhase = phase;
    else begin
      if (startFault) faultPulses++;
      if (phase != lastPhase) begin
        vectors++;
        if (expQ.size() == 0) begin
          miscompares++;
          $display("FAIL R3 phase trail: actual %0d expected no change", phase);
        end else begin
          int e;
          e = expQ.pop_front();
          if (e != int'(phase)) begin
            miscompares++;
            $display("FAIL R3 phase trail: actual %0d expected %0d", phase, e);
          end
        end
        lastPhase = phase;
      end
    end
  end

  task automatic waitQueue(input int upTo, input string tag);
    int n;
    n = 0;
    while (expQ.size() > upTo && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (expQ.size() > upTo) check({tag, " queue drain"}, expQ.size(), upTo);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion (R3)");
    summary();
  end

  initial begin
    int dur;
    idle(4);
    @(negedge clk) rstN = 1'b1;
    idle(3);
    // R1 reset state
    check("R1 phase", phase, 0);
    check("R1 gateEn", gateEn, 0);
    check("R1 detResult", detResult, 0);
    check("R1 enables", {detEnBit, classEnBit}, 0);
    check("R1 pwrEnabled", pwrEnabled, 0);

    // manual, open port verdict
    detVerdict = 3'b110;
    idle(4);
    expQ = {1, 2, 0};
    pulse(detEnSet);
    waitQueue(0, "R6");
    idle(2);
    check("R4 verdict latched", detResult, 6);
    check("R6 detect bit self-clears", detEnBit, 0);

    // manual, pass verdict, classification by timeout
    detVerdict = 3'b100;
    pulse(classEnSet);
    idle(6);
    check("R3 class enable alone stays idle", phase, 0);
    expQ = {1, 2, 3, 0};
    pulse(detEnSet);
    waitQueue(0, "R7");
    idle(2);
    check("R4 pass latched", detResult, 4);
    check("R6 both bits clear", {detEnBit, classEnBit}, 0);

    // backoff after a low-resistance verdict
    detVerdict = 3'b011;
    backoffEn = 1'b1;
    idle(4);
    expQ = {1, 2, 6, 0};
    pulse(detEnSet);
    while (phase != 3'd6) @(negedge clk);
    dur = 0;
    while (phase == 3'd6 && dur < 1000) begin
      @(negedge clk);
      dur++;
    end
    check("R5 backoff long enough", int'(dur >= (BT - 1) * P + 1), 1);
    check("R5 backoff short enough", int'(dur <= BT * P), 1);
    waitQueue(0, "R5");
    check("R5 verdict latched", detResult, 3);
    backoffEn = 1'b0;

    // automatic mode runs to power
    detVerdict = 3'b100;
    classDone = 1'b1;
    pwrGood = 1'b1;
    idle(4);
    expQ = {1, 2, 3, 4, 5};
    @(negedge clk) modeSel = 2'd2;
    waitQueue(0, "R7");
    idle(2);
    check("R9 powered", pwrEnabled, 1);
    check("R12 gate in powered", gateEn, 1);
    check("R2 auto sets enables", {detEnBit, classEnBit}, 3);
    @(negedge clk) modeSel = 2'd0;
    idle(2);
    check("R2 manual clears enables", {detEnBit, classEnBit}, 0);
    check("R2 mode change keeps power", phase, 5);

    // disconnect ignored, then honoured
    @(negedge clk) dcDisconnect = 1'b1;
    idle(20);
    check("R10 ignored when monitoring off", phase, 5);
    expQ = {0};
    @(negedge clk) dcdEn = 1'b1;
    waitQueue(0, "R10");
    check("R10 gate dropped", gateEn, 0);
    check("R10 status dropped", pwrEnabled, 0);
    dcDisconnect = 1'b0;
    dcdEn = 1'b0;

    // power-on aborts detection, then startup times out
    detVerdict = 3'b110;
    pwrGood = 1'b0;
    idle(4);
    expQ = {1};
    pulse(detEnSet);
    waitQueue(0, "R8");
    expQ = {4};
    faultPulses = 0;
    pulse(pwrOnCmd);
    waitQueue(0, "R8");
    check("R12 gate in startup", gateEn, 1);
    expQ = {0};
    waitQueue(0, "R9");
    idle(3);
    check("R9 single fault pulse", faultPulses, 1);
    check("R9 gate off after timeout", gateEn, 0);
    check("R8 aborted detect bit clear", detEnBit, 0);

    // semi-automatic: enables kept, loop stopped by power-off
    pulse(classEnSet);
    @(negedge clk) modeSel = 2'd1;
    idle(2);
    check("R2 semi keeps enables", {detEnBit, classEnBit}, 1);
    detVerdict = 3'b100;
    classDone = 1'b1;
    idle(4);
    expQ = {1, 2, 3, 0, 1, 0};
    pulse(detEnSet);
    waitQueue(1, "R11");
    pulse(pwrOffCmd);
    waitQueue(0, "R11");
    idle(3);
    check("R11 semi power-off clears enables", {detEnBit, classEnBit}, 0);
    check("R11 idle", phase, 0);

    // semi-automatic power-on from idle, then power-off
    pwrGood = 1'b1;
    idle(4);
    expQ = {4, 5};
    pulse(pwrOnCmd);
    waitQueue(0, "R8");
    idle(2);
    check("R9 powered after command", pwrEnabled, 1);
    expQ = {0};
    pulse(pwrOffCmd);
    waitQueue(0, "R11");
    check("R11 gate off", gateEn, 0);
    idle(4);
    check("R3 trail fully consumed", expQ.size(), 0);
    summary();
  end

endmodule